// File: doc/BRIEF.md
# I2C Slave Controller with Register Access

The block is a 7-bit-addressed I2C slave that a local processor services through a small register port. SDA and SCL arrive through glitch filters; the controller finds START and STOP conditions, shifts in the address byte, compares it with a programmable own address and acknowledges on a match. Each completed byte sets an interrupt flag. The processor then reads or writes one shared data register, which also clears the flag. While the flag is set after an acknowledged byte, the controller holds SCL low so the master waits for the processor.

The bus pins are modelled as open-drain pull-down enables (`*_oe_o = 1` pulls the line low). A mode bit turns the controller off and hands both pins to direct processor control, so software can run a bit-banged master. In that mode SDA is sampled on every SCL rising edge.

Register select on `reg_sel_i`: 0 selects the data register, 1 the own-address register, 2 the control/status register. Control write bits: [0] soft reset (pulse), [3] bit-bang mode, [4] SDA drive enable, [5] SDA level, [6] SCL level. Status read bits: [0] interrupt flag, [1] direction, [2] halted, [3] bit-bang mode, [4] SDA drive enable, [5] SDA level, [6] SCL level, [7] latched SDA input.

Top module: `i2c_slave_ctrl`

## Requirements
- R1: The own-address register (select 1) resets to 0x2A. After a START, an address byte whose upper 7 bits match it is acknowledged: the slave pulls SDA low during the ninth clock.
- R2: On the falling SCL edge that ends an acknowledged address byte, the interrupt flag (status bit 0, also `irq_o`) sets. The data register (select 0) then reads the address in bits [7:1] and R/W in bit 0.
- R3: Status bit 1 mirrors the received R/W bit. When it is 1, the slave sends the byte last written to the data register, MSB first.
- R4: From the ninth falling SCL edge of an acknowledged byte until the interrupt flag is cleared, the slave holds SCL low.
- R5: The interrupt flag sets after every received data byte, which the slave acknowledges and stores in the data register. It also sets after every transmitted byte, whether the master answered with ACK or NACK.
- R6: Any read or write of the data register (select 0) clears the interrupt flag.
- R7: A second data register access within one interrupt period halts the controller. It sets status bit 2, and from then on the controller drives neither line and acknowledges nothing until a soft reset.
- R8: After reset, after a STOP, or after a NACK on a transmitted byte, the controller is idle: both lines are released and no clock is stretched.
- R9: Writing control bit 0 (select 2) forces the controller idle from any state. It clears the interrupt flag and the halted state and releases both lines.
- R10: An SDA or SCL pulse shorter than FILT_CYC system clocks is ignored. A brief SDA low while SCL is high is not taken as a START.
- R11: With control bit 3 set, `scl_oe_o` is the inverse of control bit 6 (which resets to 1), `sda_oe_o` is bit 4 AND NOT bit 5, and status bit 7 holds the SDA level seen at the last SCL rising edge.
- R12: After a START with a non-matching address, the slave gives no ACK, raises no interrupt and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_sel_i | input | 2 | Register select (0 data, 1 address, 2 control/status) |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Interrupt flag |

## Verification
Write transfers carry random address-matched payloads of random length, and the bench compares every stored byte and acknowledgment. This separates the receive shift path from the address compare. Read transfers send random processor-written bytes and end with a master NACK, which shows that the transmit shifter works, that stretching holds between bytes and stops after the last one. Directed cases cover a wrong address, a short SDA glitch followed by clocking without START, a double data access, and a soft reset while SCL is stretched. Each of these should leave the slave silent or idle while the main path stays unchanged. A last phase toggles the bit-bang pins with random SDA levels to check the direct drive and the sampling on SCL rising edges.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_DATA = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT, S_HALT
  } slv_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int   FILT_CYC = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic [1:0]    sync_q;
  logic          q_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      q_q    <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] != q_q) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          q_q   <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign q_o = q_q;

  // R10: output only ever moves to the level the synchronizer held
  a_r10_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != $past(q_q)) |-> ($past(sync_q[1]) == q_q));
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slave_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              srst_i,
  output logic              irq_o,
  output logic              dir_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] data_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int CW = $clog2(DATA_W + 1);

  slv_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] shift_q, data_q;
  logic              irq_q, dir_q, touched_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      data_q    <= '0;
      irq_q     <= 1'b0;
      dir_q     <= 1'b0;
      touched_q <= 1'b0;
      mack_q    <= 1'b1;
    end else if (srst_i) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      touched_q <= 1'b0;
    end else begin
      if (acc_i) begin
        touched_q <= 1'b1;
        irq_q     <= 1'b0;
        if (wr_i) data_q <= wdata_i;
      end
      unique case (state_q)
        S_ADDR, S_RX: begin
          if (scl_rise_i) begin
            shift_q <= {shift_q[DATA_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CW'(DATA_W)) begin
            if (state_q == S_RX) begin
              data_q  <= shift_q;
              state_q <= S_RX_ACK;
            end else if (shift_q[DATA_W-1:1] == own_addr_i) begin
              data_q  <= shift_q;
              dir_q   <= shift_q[0];
              state_q <= S_ADDR_ACK;
            end else begin
              state_q <= S_IDLE;  // not addressed: silent until next START
            end
          end
        end
        S_ADDR_ACK, S_RX_ACK: begin
          if (scl_fall_i) begin
            irq_q     <= 1'b1;
            touched_q <= 1'b0;
            state_q   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!irq_q) begin
            cnt_q <= '0;
            if (dir_q) begin
              shift_q <= data_q;
              state_q <= S_TX;
            end else begin
              state_q <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == CW'(DATA_W)) state_q <= S_TX_ACK;
            else shift_q <= {shift_q[DATA_W-2:0], 1'b0};
          end
        end
        S_TX_ACK: begin
          if (scl_rise_i) begin
            mack_q <= sda_i;
          end else if (scl_fall_i) begin
            irq_q     <= 1'b1;
            touched_q <= 1'b0;
            state_q   <= mack_q ? S_IDLE : S_WAIT;
          end
        end
        default: ;
      endcase
      if (state_q != S_HALT) begin
        if (stop_i) begin
          state_q <= S_IDLE;
        end else if (start_i) begin
          state_q <= S_ADDR;
          cnt_q   <= '0;
        end
        if (!en_i) state_q <= S_IDLE;
      end
      if (acc_i && touched_q) state_q <= S_HALT;
    end
  end

  assign irq_o    = irq_q;
  assign dir_o    = dir_q;
  assign halted_o = (state_q == S_HALT);
  assign data_o   = data_q;
  assign scl_oe_o = (state_q == S_WAIT);
  assign sda_oe_o = (state_q == S_ADDR_ACK) || (state_q == S_RX_ACK) ||
                    ((state_q == S_TX) && !shift_q[DATA_W-1]);

  a_r4_wait_entered_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && $past(state_q) != S_WAIT) |-> irq_q);
  a_r6_access_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && irq_q && !srst_i && !scl_fall_i) |=> !irq_q);
  a_r7_second_touch_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && touched_q && !srst_i) |=> (state_q == S_HALT));
  a_r8_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && state_q != S_HALT && !srst_i && !(acc_i && touched_q)) |=> (state_q == S_IDLE));
  a_r9_soft_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (state_q == S_IDLE && !irq_q));
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter int                FILT_CYC = 3,
  parameter logic [ADDR_W-1:0] DEF_ADDR = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic scl_f, sda_f, start, stop, scl_rise, scl_fall;
  logic acc, srst, fsm_dir, fsm_halted, fsm_scl_oe, fsm_sda_oe, fsm_irq;
  logic [DATA_W-1:0] fsm_data;
  logic [ADDR_W-1:0] addr_q;
  logic mode_q, bb_sda_en_q, bb_sda_q, bb_scl_q, bb_in_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk_i, .rst_ni, .d_i(raw[g]), .q_o(filt[g])
    );
  end
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  assign acc  = (reg_wr_i || reg_rd_i) && (reg_sel_i == SEL_DATA);
  assign srst = reg_wr_i && (reg_sel_i == SEL_CTRL) && reg_wdata_i[0];

  i2c_slave_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(!mode_q), .sda_i(sda_f),
    .start_i(start), .stop_i(stop), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .own_addr_i(addr_q), .acc_i(acc), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .srst_i(srst), .irq_o(fsm_irq), .dir_o(fsm_dir), .halted_o(fsm_halted),
    .data_o(fsm_data), .scl_oe_o(fsm_scl_oe), .sda_oe_o(fsm_sda_oe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= DEF_ADDR;
      mode_q      <= 1'b0;
      bb_sda_en_q <= 1'b0;
      bb_sda_q    <= 1'b0;
      bb_scl_q    <= 1'b1;
      bb_in_q     <= 1'b0;
    end else begin
      if (reg_wr_i && reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i[ADDR_W-1:0];
      if (reg_wr_i && reg_sel_i == SEL_CTRL) begin
        mode_q      <= reg_wdata_i[3];
        bb_sda_en_q <= reg_wdata_i[4];
        bb_sda_q    <= reg_wdata_i[5];
        bb_scl_q    <= reg_wdata_i[6];
      end
      if (scl_rise) bb_in_q <= sda_f;
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_DATA: reg_rdata_o = fsm_data;
      SEL_ADDR: reg_rdata_o = {1'b0, addr_q};
      SEL_CTRL: reg_rdata_o = {bb_in_q, bb_scl_q, bb_sda_q, bb_sda_en_q,
                               mode_q, fsm_halted, fsm_dir, fsm_irq};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign scl_oe_o = mode_q ? !bb_scl_q : fsm_scl_oe;
  assign sda_oe_o = mode_q ? (bb_sda_en_q && !bb_sda_q) : fsm_sda_oe;
  assign irq_o    = fsm_irq;

  a_r11_latch_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bb_in_q) |-> $past(scl_rise));
endmodule

// File: tb/i2c_slave_ctrl_bench.sv
module i2c_slave_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 20;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, irq, scl_line, sda_line;
  logic [1:0] sel = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_slave_ctrl u_i2c_slave_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic reg_acc(input logic [1:0] s, input logic w, input logic [7:0] d,
                         output logic [7:0] r);
    @(negedge clk);
    sel = s; wr = w; rd = !w; wdata = d;
    #(CLK_P/4);
    r = rdata;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic clock_bit(input logic v, output logic r);
    m_sda_low = !v;
    wait_q();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_q();
    r = sda_line;
    wait_q();
    m_scl_low = 1'b1;
    wait_q();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      b[i] = r;
    end
    clock_bit(!give_ack, r);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0;
    wait_q();
    m_sda_low = 1'b1;
    wait_q();
    m_scl_low = 1'b1;
    wait_q();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1;
    wait_q();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_q();
    m_sda_low = 1'b0;
    wait_q();
  endtask

  task automatic write_xfer(input int n);
    logic ack;
    logic [7:0] r, b;
    bus_start();
    write_byte(exp_byte(OWN, 1'b0), ack);
    chk("R1 addr ack", ack, 1);
    chk("R2 irq after addr", irq, 1);
    chk("R4 scl stretched", scl_oe, 1);
    reg_acc(2'd2, 1'b0, 8'h00, r);
    chk("R3 dir bit write", r[1], 0);
    reg_acc(2'd0, 1'b0, 8'h00, r);
    chk("R2 data holds addr+rw", r, exp_byte(OWN, 1'b0));
    chk("R6 irq cleared by read", irq, 0);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      write_byte(b, ack);
      chk("R5 data ack", ack, 1);
      chk("R5 irq after rx byte", irq, 1);
      reg_acc(2'd0, 1'b0, 8'h00, r);
      chk("R5 rx byte stored", r, b);
    end
    bus_stop();
    chk("R8 idle after stop", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic read_xfer(input int n);
    logic ack;
    logic [7:0] r, b, got;
    bus_start();
    write_byte(exp_byte(OWN, 1'b1), ack);
    chk("R1 addr ack (read)", ack, 1);
    reg_acc(2'd2, 1'b0, 8'h00, r);
    chk("R3 dir bit read", r[1:0], 2'b11);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      reg_acc(2'd0, 1'b1, b, r);
      chk("R6 irq cleared by write", irq, 0);
      read_byte(got, i < n - 1);
      chk("R3 tx byte", got, b);
      chk("R5 irq after tx byte", irq, 1);
      if (i < n - 1) chk("R4 stretch after acked tx", scl_oe, 1);
      else chk("R8 released after nack", {scl_oe, sda_oe}, 0);
    end
    reg_acc(2'd0, 1'b0, 8'h00, r);
    chk("R6 irq cleared after nack", irq, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic ack, bit_v;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R8 reset lines", {scl_oe, sda_oe, irq}, 0);
    reg_acc(2'd2, 1'b0, 8'h00, r);
    chk("R11 reset status", r, 8'h40);
    reg_acc(2'd1, 1'b0, 8'h00, r);
    chk("R1 reset address", r, {1'b0, OWN});

    for (int t = 0; t < 3; t++) write_xfer(1 + int'($urandom_range(3)));
    for (int t = 0; t < 2; t++) read_xfer(2 + int'($urandom_range(2)));

    // R12 wrong address
    bus_start();
    write_byte(exp_byte(OWN ^ 7'h01, 1'b0), ack);
    chk("R12 no ack on mismatch", ack, 0);
    chk("R12 no irq on mismatch", irq, 0);
    write_byte(8'h5A, ack);
    chk("R12 data ignored", {ack, irq}, 0);
    bus_stop();

    // R10 short SDA glitch is no START
    @(negedge clk); m_sda_low = 1'b1;
    @(negedge clk); @(negedge clk); m_sda_low = 1'b0;
    wait_q();
    m_scl_low = 1'b1;
    wait_q();
    write_byte(exp_byte(OWN, 1'b0), ack);
    chk("R10 glitch not a start", {ack, irq}, 0);
    bus_stop();

    // R7 double access halts
    bus_start();
    write_byte(exp_byte(OWN, 1'b0), ack);
    chk("R2 irq before halt", irq, 1);
    reg_acc(2'd0, 1'b0, 8'h00, r);
    reg_acc(2'd0, 1'b0, 8'h00, r);
    reg_acc(2'd2, 1'b0, 8'h00, r);
    chk("R7 halted flag", r[2], 1);
    write_byte(8'hC3, ack);
    chk("R7 halted ignores bus", {ack, irq, scl_oe}, 0);
    bus_stop();
    reg_acc(2'd2, 1'b1, 8'h41, r);
    reg_acc(2'd2, 1'b0, 8'h00, r);
    chk("R9 halt cleared", r[2:0], 0);

    // R9 soft reset while stretching
    bus_start();
    write_byte(exp_byte(OWN, 1'b0), ack);
    chk("R4 stretch before srst", scl_oe, 1);
    reg_acc(2'd2, 1'b1, 8'h41, r);
    @(negedge clk);
    chk("R9 srst releases", {scl_oe, sda_oe, irq}, 0);
    bus_stop();
    write_xfer(1);

    // R11 bit-bang path
    reg_acc(2'd2, 1'b1, 8'h58, r);
    chk("R11 drive pins", {scl_oe, sda_oe}, 2'b01);
    for (int i = 0; i < 4; i++) begin
      bit_v = 1'($urandom);
      reg_acc(2'd2, 1'b1, 8'h08, r);
      chk("R11 scl low", scl_oe, 1);
      m_sda_low = !bit_v;
      repeat (10) @(negedge clk);
      reg_acc(2'd2, 1'b1, 8'h48, r);
      repeat (12) @(negedge clk);
      reg_acc(2'd2, 1'b0, 8'h00, r);
      chk("R11 sda latched on rise", r[7], bit_v);
    end
    m_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    reg_acc(2'd2, 1'b1, 8'h40, r);
    repeat (10) @(negedge clk);
    chk("R8 idle after bit-bang", {scl_oe, sda_oe, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule